// File: doc/BRIEF.md
# SDRAM Power-Up Command Sequencer

This block produces the command stream that brings an SDRAM device out of power-up. Once the controller is enabled and its start bit is set, the sequencer waits for the first attempt to access SDRAM space. It then issues a precharge of all banks, a set number of auto-refresh commands, and a mode register load. A configuration bit selects whether the refreshes come before or after the mode register load. Before the precharge it can insert a fixed start delay. Before the mode register load it can write the extended mode register, which is used by low-power parts.

The NOP gaps between commands come from the precharge time and the active-to-precharge time given on the inputs. When the sequence is finished, a done flag is raised. The access that triggered the sequence is held until done is high. The flag stays high until the controller enable is cleared. Clearing the enable also cancels a sequence that is still running, and the next access after re-enabling starts a new one.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: No command other than NOP is issued unless `ctrl_en`, `start_en` and `access_req` are all high at the same clock edge while the block is idle. The first command appears in the cycle after that edge.
- R2: Commands use the codes NOP=000, PRE=001, REF=010, MRS=011, EMRS=100. With `seq_mode`=0 the order is PRE, then REF_COUNT (default 8) REF commands, then MRS.
- R3: With `seq_mode`=1 the order is PRE, then MRS, then the REF_COUNT REF commands.
- R4: With `dly_en`=1, START_DLY (default 15) NOP cycles come before the PRE. With `dly_en`=0 the PRE comes first.
- R5: A PRE is followed by `trp` NOP cycles. Each REF is followed by `tras`+`trp` NOP cycles. MRS and EMRS are each followed by 2 NOP cycles. A gap that works out to zero is stretched to one cycle.
- R6: During MRS, `addr` has 000 in bits 2:0 (burst length 1), 0 in bit 3 (sequential), `cas_lat` in bits 6:4, and zero in all other bits.
- R7: When `ext_en`=1, exactly one EMRS is issued directly before the MRS, with its 2-cycle gap in between. During EMRS, `addr` has `pasr` in bits 2:0, `tcsr` in bits 4:3, and zero elsewhere. When `ext_en`=0, no EMRS is issued.
- R8: During PRE, `addr` has bit 10 high and every other bit low. During NOP and REF, `addr` is zero.
- R9: `done` rises in the cycle after the last gap ends. It stays high while `ctrl_en` is high, and further accesses cause no commands.
- R10: When `ctrl_en` is low at a clock edge, `done` is low and `cmd` is NOP in the next cycle, even in the middle of a sequence. After re-enabling, a new access starts the sequence again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctrl_en | input | 1 | Controller enable; low aborts the sequence and clears done |
| start_en | input | 1 | Allows the power-up sequence to start |
| access_req | input | 1 | An access to SDRAM address space is being attempted |
| seq_mode | input | 1 | 0: refreshes before MRS; 1: MRS before refreshes |
| dly_en | input | 1 | Insert the start delay before the precharge |
| ext_en | input | 1 | Issue the extended mode register write |
| cas_lat | input | 3 | CAS latency written into the mode word |
| trp | input | TW | Precharge gap in cycles |
| tras | input | TW | Active-to-precharge time in cycles |
| pasr | input | 3 | Partial-array refresh field of the extended word |
| tcsr | input | 2 | Temperature-compensation field of the extended word |
| cmd | output | 3 | SDRAM command code |
| addr | output | AW | Address bits that go with the command |
| done | output | 1 | Power-up sequence complete |

## Verification
The bench builds the block with its default parameters: REF_COUNT 8, START_DLY 15, TW 4, AW 13. With a 4-bit timing width, the largest refresh gap is 30 cycles, which exercises the widest path of the wait counter. Zero timing values exercise the one-cycle minimum. The vector table covers both orders, with and without the start delay and the extended write. For each vector the bench compares the command and address against an expected timeline cycle by cycle. It also aborts one sequence midway and reruns it from the beginning.

// File: rtl/sdram_pwrup_pkg.sv
package sdram_pwrup_pkg;

  localparam int CAS_W  = 3;
  localparam int PASR_W = 3;
  localparam int TCSR_W = 2;

  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_PRE  = 3'd1,
    CMD_REF  = 3'd2,
    CMD_MRS  = 3'd3,
    CMD_EMRS = 3'd4
  } sdr_cmd_e;

  typedef enum logic [3:0] {
    S_IDLE, S_DELAY, S_PRE, S_PRE_W, S_REF, S_REF_W,
    S_EMRS, S_EMRS_W, S_MRS, S_MRS_W, S_DONE
  } seq_state_e;

  // a gap of zero cycles is stretched to one
  function automatic int clamp_gap(input int cyc);
    return (cyc < 1) ? 1 : cyc;
  endfunction

  // NOP cycles that follow each auto-refresh
  function automatic int refresh_gap(input int ras_cyc, input int rp_cyc);
    return clamp_gap(ras_cyc + rp_cyc);
  endfunction

endpackage

// File: rtl/sdram_pwrup_timer.sv
module sdram_pwrup_timer #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_len,
  output logic          expired
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_len - 1'b1;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  p_load_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(load_len) - 1'b1));

  p_count_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/sdram_pwrup_fsm.sv
module sdram_pwrup_fsm
  import sdram_pwrup_pkg::*;
#(
  parameter int TW        = 4,
  parameter int CW        = 6,
  parameter int REF_COUNT = 8,
  parameter int START_DLY = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctrl_en,
  input  logic          start_en,
  input  logic          access_req,
  input  logic          seq_mode,
  input  logic          dly_en,
  input  logic          ext_en,
  input  logic [TW-1:0] trp,
  input  logic [TW-1:0] tras,
  input  logic          tmr_expired,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_len,
  output sdr_cmd_e      cmd,
  output logic          done
);

  localparam int RW = $clog2(REF_COUNT + 1);

  seq_state_e    st_q, st_d;
  logic [RW-1:0] ref_cnt_q;
  logic          go;
  logic          refs_complete;
  seq_state_e    mode_entry;
  logic [CW-1:0] pre_len, ref_len;

  assign go            = ctrl_en && start_en && access_req;
  assign refs_complete = (ref_cnt_q == RW'(REF_COUNT));
  assign mode_entry    = ext_en ? S_EMRS : S_MRS;
  assign pre_len       = CW'(clamp_gap(int'(trp)));
  assign ref_len       = CW'(refresh_gap(int'(tras), int'(trp)));

  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    tmr_len  = '0;
    unique case (st_q)
      S_IDLE: if (go) begin
        if (dly_en) begin
          st_d = S_DELAY; tmr_load = 1'b1; tmr_len = CW'(START_DLY);
        end else begin
          st_d = S_PRE;
        end
      end
      S_DELAY:  if (tmr_expired) st_d = S_PRE;
      S_PRE: begin
        st_d = S_PRE_W; tmr_load = 1'b1; tmr_len = pre_len;
      end
      S_PRE_W:  if (tmr_expired) st_d = seq_mode ? mode_entry : S_REF;
      S_REF: begin
        st_d = S_REF_W; tmr_load = 1'b1; tmr_len = ref_len;
      end
      S_REF_W: if (tmr_expired) begin
        if (!refs_complete) st_d = S_REF;
        else                st_d = seq_mode ? S_DONE : mode_entry;
      end
      S_EMRS: begin
        st_d = S_EMRS_W; tmr_load = 1'b1; tmr_len = CW'(2);
      end
      S_EMRS_W: if (tmr_expired) st_d = S_MRS;
      S_MRS: begin
        st_d = S_MRS_W; tmr_load = 1'b1; tmr_len = CW'(2);
      end
      S_MRS_W:  if (tmr_expired) st_d = seq_mode ? S_REF : S_DONE;
      S_DONE:   st_d = S_DONE;
      default:  st_d = S_IDLE;
    endcase
    if (!ctrl_en) begin
      st_d     = S_IDLE;
      tmr_load = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= S_IDLE;
      ref_cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == S_IDLE)     ref_cnt_q <= '0;
      else if (st_q == S_REF) ref_cnt_q <= ref_cnt_q + 1'b1;
    end
  end

  always_comb begin
    unique case (st_q)
      S_PRE:   cmd = CMD_PRE;
      S_REF:   cmd = CMD_REF;
      S_EMRS:  cmd = CMD_EMRS;
      S_MRS:   cmd = CMD_MRS;
      default: cmd = CMD_NOP;
    endcase
  end

  assign done = (st_q == S_DONE);

  p_hold_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_IDLE && !go) |=> (cmd == CMD_NOP));

  p_pre_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_IDLE && go && !dly_en) |=> (cmd == CMD_PRE));

  p_ref_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ref_cnt_q <= RW'(REF_COUNT));

  p_emrs_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_EMRS) |=> (cmd == CMD_NOP));

  p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ctrl_en) |=> done);

  p_off_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_en |=> (!done && cmd == CMD_NOP));

endmodule

// File: rtl/sdram_pwrup_addr.sv
module sdram_pwrup_addr
  import sdram_pwrup_pkg::*;
#(
  parameter int AW = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sdr_cmd_e          cmd,
  input  logic [CAS_W-1:0]  cas_lat,
  input  logic [PASR_W-1:0] pasr,
  input  logic [TCSR_W-1:0] tcsr,
  output logic [AW-1:0]     addr
);

  localparam int A_ALLBANK = 10;

  // burst length 1 (000), sequential (0), CAS latency in 6:4
  function automatic logic [AW-1:0] mode_word(input logic [CAS_W-1:0] cl);
    logic [AW-1:0] w;
    w      = '0;
    w[6:4] = cl;
    return w;
  endfunction

  function automatic logic [AW-1:0] ext_word(input logic [PASR_W-1:0] pa,
                                             input logic [TCSR_W-1:0] tc);
    logic [AW-1:0] w;
    w      = '0;
    w[2:0] = pa;
    w[4:3] = tc;
    return w;
  endfunction

  function automatic logic [AW-1:0] pre_word();
    logic [AW-1:0] w;
    w            = '0;
    w[A_ALLBANK] = 1'b1;
    return w;
  endfunction

  always_comb begin
    unique case (cmd)
      CMD_PRE:  addr = pre_word();
      CMD_MRS:  addr = mode_word(cas_lat);
      CMD_EMRS: addr = ext_word(pasr, tcsr);
      default:  addr = '0;
    endcase
  end

  p_pre_a10_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_PRE) |-> (addr[A_ALLBANK] && $countones(addr) == 1));

  p_quiet_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_NOP || cmd == CMD_REF) |-> (addr == '0));

  p_mrs_burst_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_MRS) |-> (addr[3:0] == 4'b0000 && addr[AW-1:7] == '0));

endmodule

// File: rtl/sdram_pwrup_seq.sv
module sdram_pwrup_seq
  import sdram_pwrup_pkg::*;
#(
  parameter int TW        = 4,
  parameter int AW        = 13,
  parameter int REF_COUNT = 8,
  parameter int START_DLY = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctrl_en,
  input  logic          start_en,
  input  logic          access_req,
  input  logic          seq_mode,
  input  logic          dly_en,
  input  logic          ext_en,
  input  logic [2:0]    cas_lat,
  input  logic [TW-1:0] trp,
  input  logic [TW-1:0] tras,
  input  logic [2:0]    pasr,
  input  logic [1:0]    tcsr,
  output logic [2:0]    cmd,
  output logic [AW-1:0] addr,
  output logic          done
);

  localparam int GAP_MAX  = 2 * (2 ** TW);
  localparam int WAIT_MAX = (START_DLY > GAP_MAX) ? START_DLY : GAP_MAX;
  localparam int CW       = $clog2(WAIT_MAX + 1);

  logic          tmr_load, tmr_expired;
  logic [CW-1:0] tmr_len;
  sdr_cmd_e      cmd_w;

  sdram_pwrup_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_len (tmr_len),
    .expired  (tmr_expired)
  );

  sdram_pwrup_fsm #(
    .TW(TW), .CW(CW), .REF_COUNT(REF_COUNT), .START_DLY(START_DLY)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrl_en     (ctrl_en),
    .start_en    (start_en),
    .access_req  (access_req),
    .seq_mode    (seq_mode),
    .dly_en      (dly_en),
    .ext_en      (ext_en),
    .trp         (trp),
    .tras        (tras),
    .tmr_expired (tmr_expired),
    .tmr_load    (tmr_load),
    .tmr_len     (tmr_len),
    .cmd         (cmd_w),
    .done        (done)
  );

  sdram_pwrup_addr #(.AW(AW)) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd     (cmd_w),
    .cas_lat (cas_lat),
    .pasr    (pasr),
    .tcsr    (tcsr),
    .addr    (addr)
  );

  assign cmd = cmd_w;

endmodule

// File: tb/sdram_pwrup_seq_tb.sv
module sdram_pwrup_seq_tb;

  localparam int NREF = 8;
  localparam int NDLY = 15;
  localparam int NV   = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_en = 1'b0, start_en = 1'b0, access_req = 1'b0;
  logic        seq_mode = 1'b0, dly_en = 1'b0, ext_en = 1'b0;
  logic [2:0]  cas_lat = '0;
  logic [3:0]  trp = '0, tras = '0;
  logic [2:0]  pasr = '0;
  logic [1:0]  tcsr = '0;
  logic [2:0]  cmd;
  logic [12:0] addr;
  logic        done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  sdram_pwrup_seq u_dut (
    .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .start_en(start_en),
    .access_req(access_req), .seq_mode(seq_mode), .dly_en(dly_en),
    .ext_en(ext_en), .cas_lat(cas_lat), .trp(trp), .tras(tras),
    .pasr(pasr), .tcsr(tcsr), .cmd(cmd), .addr(addr), .done(done)
  );

  // {mode, dly, ext, cas[3], trp[4], tras[4], pasr[3], tcsr[2]}
  localparam logic [18:0] VECS [NV] = '{
    {1'b0, 1'b0, 1'b0, 3'd2, 4'd2,  4'd5,  3'd0, 2'd0},
    {1'b1, 1'b0, 1'b0, 3'd3, 4'd2,  4'd3,  3'd0, 2'd0},
    {1'b0, 1'b1, 1'b1, 3'd2, 4'd1,  4'd2,  3'd5, 2'd2},
    {1'b1, 1'b1, 1'b1, 3'd3, 4'd3,  4'd4,  3'd3, 2'd1},
    {1'b0, 1'b0, 1'b0, 3'd1, 4'd0,  4'd0,  3'd0, 2'd0},
    {1'b1, 1'b0, 1'b1, 3'd7, 4'd15, 4'd15, 3'd7, 2'd3}
  };

  int          exp_c [512];
  logic [12:0] exp_a [512];
  int          exp_n;

  task automatic check(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  task automatic push(input int c, input logic [12:0] a);
    exp_c[exp_n] = c;
    exp_a[exp_n] = a;
    exp_n++;
  endtask

  task automatic push_nops(input int n);
    for (int i = 0; i < n; i++) push(0, 13'd0);
  endtask

  task automatic push_mode_part(input logic ext, input logic [2:0] cl,
                                input logic [2:0] pa, input logic [1:0] tc);
    if (ext) begin
      push(4, {8'd0, tc, pa});
      push_nops(2);
    end
    push(3, {6'd0, cl, 4'd0});
    push_nops(2);
  endtask

  task automatic push_refs(input int gap);
    for (int i = 0; i < NREF; i++) begin
      push(2, 13'd0);
      push_nops(gap);
    end
  endtask

  task automatic build(input logic [18:0] v);
    int rp, rg;
    rp = (v[12:9] == 0) ? 1 : int'(v[12:9]);
    rg = int'(v[12:9]) + int'(v[8:5]);
    if (rg == 0) rg = 1;
    exp_n = 0;
    if (v[17]) push_nops(NDLY);
    push(1, 13'h0400);
    push_nops(rp);
    if (v[18]) begin
      push_mode_part(v[16], v[15:13], v[4:2], v[1:0]);
      push_refs(rg);
    end else begin
      push_refs(rg);
      push_mode_part(v[16], v[15:13], v[4:2], v[1:0]);
    end
  endtask

  // R1 R2 R3 R4 R5 R6 R7 R8 R9 R10 checked per cycle against the timeline
  task automatic run_vec(input logic [18:0] v, input int idx);
    build(v);
    @(negedge clk);
    ctrl_en = 1'b1; start_en = 1'b1; access_req = 1'b0;
    seq_mode = v[18]; dly_en = v[17]; ext_en = v[16];
    cas_lat = v[15:13]; trp = v[12:9]; tras = v[8:5];
    pasr = v[4:2]; tcsr = v[1:0];
    repeat (3) begin
      @(negedge clk);
      check("R1 idle without access", int'(cmd), 0);
    end
    access_req = 1'b1;
    for (int t = 0; t < exp_n + 3; t++) begin
      @(negedge clk);
      if (t < exp_n) begin
        check($sformatf("R2/R3 v%0d cmd t=%0d", idx, t), int'(cmd), exp_c[t]);
        check($sformatf("R6/R7/R8 v%0d addr t=%0d", idx, t), int'(addr), int'(exp_a[t]));
        check($sformatf("R9 v%0d done low t=%0d", idx, t), int'(done), 0);
      end else begin
        check($sformatf("R9 v%0d done high t=%0d", idx, t), int'(done), 1);
        check($sformatf("R9 v%0d quiet t=%0d", idx, t), int'(cmd), 0);
      end
    end
    repeat (5) begin
      @(negedge clk);
      check("R9 done sticky under access", int'(done), 1);
      check("R9 no further commands", int'(cmd), 0);
    end
    ctrl_en = 1'b0;
    access_req = 1'b0;
    @(negedge clk);
    check("R10 done cleared", int'(done), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R2 reset cmd NOP", int'(cmd), 0);
    check("R8 reset addr zero", int'(addr), 0);
    check("R9 reset done low", int'(done), 0);
    rst_n = 1'b1;

    // R1: access without start bit, then start bit without access
    @(negedge clk);
    ctrl_en = 1'b1; start_en = 1'b0; access_req = 1'b1;
    repeat (10) begin
      @(negedge clk);
      check("R1 no start bit", int'(cmd), 0);
    end
    start_en = 1'b1; access_req = 1'b0;
    repeat (10) begin
      @(negedge clk);
      check("R1 no access", int'(cmd), 0);
    end
    ctrl_en = 1'b0; start_en = 1'b0;

    for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

    // R10: abort midway through the refreshes, then restart cleanly
    @(negedge clk);
    ctrl_en = 1'b1; start_en = 1'b1; seq_mode = 1'b0; dly_en = 1'b0;
    ext_en = 1'b0; trp = 4'd2; tras = 4'd5; access_req = 1'b1;
    repeat (8) @(negedge clk);
    ctrl_en = 1'b0;
    @(negedge clk);
    check("R10 abort cmd NOP", int'(cmd), 0);
    check("R10 abort done low", int'(done), 0);
    repeat (20) begin
      @(negedge clk);
      check("R10 stays idle while disabled", int'(cmd), 0);
    end
    access_req = 1'b0;
    run_vec(VECS[0], 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule